// File: doc/BRIEF.md
# Transmit Packet Stream Demultiplexer

This block sits behind the receive side of a transmit packet buffer and splits a stream of fixed-size packets into three destinations. It pops one 16-bit word per cycle from a show-ahead input FIFO. It decodes the first header word to find the destination and the payload length. It then pushes the words into a command FIFO or into one of two per-channel sample FIFOs. Destinations never pull from this block.

Sample packets keep their four-word header, so a later scheduler can read the timestamp and the length. Command packets lose their header and deliver only the payload. The block reads and discards every word after the payload, up to the end of the fixed packet. A full destination stalls the input pops. Words that go nowhere (padding, command headers, packets for unknown channels) drain even while every destination is full.

The sequencer has four states. FRAME_HEAD takes the first header word and always moves to HEAD_TAIL. HEAD_TAIL takes header words 1 to 3. After word 3 it moves to PAYLOAD, or to PADDING when the payload is empty. PAYLOAD moves on after its last payload word: to FRAME_HEAD if that word ends the packet, otherwise to PADDING. PADDING returns to FRAME_HEAD after the last word of the packet. Every state waits while no word is popped.

Top module: `tx_pkt_demux`

## Requirements
- R1: After reset the block is in FRAME_HEAD. The malformed-length count is 0, and no destination is written while the input is empty.
- R2: Bits [15:11] of header word 0 select the route. 0 selects sample channel 0, 1 selects sample channel 1, and 31 marks a command packet.
- R3: A sample packet delivers its 4 header words and then its payload words, in input order, to the FIFO of its channel and to no other FIFO.
- R4: A command packet delivers only its payload words, in order, to the command FIFO. Its 4 header words are popped but written nowhere.
- R5: The payload is ceil(L/2) words, where L is the byte count in bits [8:0] of header word 0. Every packet is exactly 256 words. The words after the payload are popped and discarded.
- R6: A packet whose channel value is 2 to 30 is popped in full (256 words) and nothing of it is written.
- R7: While the FIFO that the current word goes to is full, no word is popped, so no word is lost or reordered. Words that go to no FIFO are popped whatever the full flags are.
- R8: When ceil(L/2) exceeds 252, the payload is clamped to 252 words and the malformed-length count rises by one (saturating).
- R9: A destination is written only in a cycle in which the input word is popped. The written data equals that word, and at most one destination is written per cycle.
- R10: Header bits [10:9] and header word 1 have no effect on routing or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input FIFO holds a word |
| in_data | input | 16 | Head word of the input FIFO |
| in_rd | output | 1 | Pop the input FIFO this cycle |
| cmd_full | input | 1 | Command FIFO full |
| cmd_wr | output | 1 | Push into command FIFO |
| cmd_data | output | 16 | Command FIFO write data |
| ch_full | input | 2 | Sample FIFO full, bit per channel |
| ch_wr | output | 2 | Push into sample FIFO, bit per channel |
| ch_data | output | 16 | Sample FIFO write data, shared by both channels |
| bad_len_cnt | output | 8 | Count of packets with a clamped length |

## Verification
The word counter, the latched destination and the payload length decide where every later word goes. If any of them is wrong, the fault shows as a miscount in the current packet, and the next header is then read from the wrong word. That misroutes the next packet completely. So each packet's word count and contents are compared per destination, and the following packet is checked as well. Such faults are therefore exposed within one packet of their cause. Stall behaviour shows in the cycle itself: the pop pin must stay low while the selected FIFO is full.

// File: rtl/tx_demux_pkg.sv
package tx_demux_pkg;
    localparam int DATA_W    = 16;
    localparam int HDR_WORDS = 4;
    localparam int CHAN_LSB  = 11;
    localparam int CHAN_W    = 5;
    localparam int LEN_W     = 9;
    localparam logic [CHAN_W-1:0] CMD_CHAN = '1;

    typedef enum logic [1:0] {DST_CMD, DST_CH0, DST_CH1, DST_NONE} dest_t;
    typedef enum logic [1:0] {FRAME_HEAD, HEAD_TAIL, PAYLOAD, PADDING} seq_state_t;
endpackage

// File: rtl/txd_hdr_decode.sv
module txd_hdr_decode
    import tx_demux_pkg::*;
#(
    parameter int PKT_WORDS = 256,
    localparam int CW = $clog2(PKT_WORDS + 1)
) (
    input  logic [DATA_W-1:0] word,
    output dest_t             dest,
    output logic [CW-1:0]     pl_words,
    output logic              too_long
);
    localparam int MAX_PL = PKT_WORDS - HDR_WORDS;

    logic [CHAN_W-1:0] chan;
    logic [LEN_W-1:0]  nbytes;
    logic [31:0]       raw;

    always_comb begin
        chan   = word[CHAN_LSB +: CHAN_W];
        nbytes = word[LEN_W-1:0];
        raw    = (32'(nbytes) + 32'd1) >> 1;
        too_long = raw > 32'(MAX_PL);
        pl_words = too_long ? CW'(MAX_PL) : CW'(raw);
        if (chan == CMD_CHAN)            dest = DST_CMD;
        else if (chan == CHAN_W'(0))     dest = DST_CH0;
        else if (chan == CHAN_W'(1))     dest = DST_CH1;
        else                             dest = DST_NONE;
    end
endmodule

// File: rtl/txd_err_count.sv
module txd_err_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (bump && count != '1) count <= count + 1'b1;
    end

    a_r8_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count >= $past(count));
    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && count != '1) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/txd_route_fsm.sv
module txd_route_fsm
    import tx_demux_pkg::*;
#(
    parameter int PKT_WORDS = 256,
    localparam int CW = $clog2(PKT_WORDS + 1),
    localparam int IW = $clog2(PKT_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  dest_t         hdr_dest,
    input  logic [CW-1:0] hdr_pl,
    input  logic          hdr_bad,
    input  logic          cmd_full,
    input  logic [1:0]    ch_full,
    output logic          in_rd,
    output logic          cmd_wr,
    output logic [1:0]    ch_wr,
    output logic          bump
);
    seq_state_t    state, nxt;
    dest_t         dest_q, cur_dest;
    logic [CW-1:0] pl_q;
    logic [IW-1:0] cnt;
    logic          want_wr, blocked, last_hdr, last_body, last_pkt;

    // State register and per-packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FRAME_HEAD;
            dest_q <= DST_NONE;
            pl_q   <= '0;
            cnt    <= '0;
        end else if (in_rd) begin
            state <= nxt;
            cnt   <= (nxt == FRAME_HEAD) ? '0 : cnt + 1'b1;
            if (state == FRAME_HEAD) begin
                dest_q <= hdr_dest;
                pl_q   <= hdr_pl;
            end
        end
    end

    // Outputs and next state
    always_comb begin
        cur_dest  = (state == FRAME_HEAD) ? hdr_dest : dest_q;
        last_hdr  = 32'(cnt) == HDR_WORDS - 1;
        last_body = 32'(cnt) == HDR_WORDS - 1 + 32'(pl_q);
        last_pkt  = 32'(cnt) == PKT_WORDS - 1;
        want_wr   = 1'b0;
        nxt       = state;
        unique case (state)
            FRAME_HEAD: begin
                want_wr = cur_dest inside {DST_CH0, DST_CH1};
                nxt     = HEAD_TAIL;
            end
            HEAD_TAIL: begin
                want_wr = cur_dest inside {DST_CH0, DST_CH1};
                if (last_hdr) nxt = (pl_q == '0) ? PADDING : PAYLOAD;
            end
            PAYLOAD: begin
                want_wr = cur_dest != DST_NONE;
                if (last_body) nxt = last_pkt ? FRAME_HEAD : PADDING;
            end
            PADDING: begin
                if (last_pkt) nxt = FRAME_HEAD;
            end
        endcase
        unique case (cur_dest)
            DST_CMD:  blocked = want_wr && cmd_full;
            DST_CH0:  blocked = want_wr && ch_full[0];
            DST_CH1:  blocked = want_wr && ch_full[1];
            DST_NONE: blocked = 1'b0;
        endcase
        in_rd    = in_valid && !blocked;
        cmd_wr   = in_rd && want_wr && cur_dest == DST_CMD;
        ch_wr[0] = in_rd && want_wr && cur_dest == DST_CH0;
        ch_wr[1] = in_rd && want_wr && cur_dest == DST_CH1;
        bump     = in_rd && state == FRAME_HEAD && hdr_bad;
    end

    a_r9_write_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr || ch_wr != 2'b00) |-> in_rd);
    a_r9_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wr, ch_wr}));
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr |-> !cmd_full) and (ch_wr[0] |-> !ch_full[0]) and (ch_wr[1] |-> !ch_full[1]));
    a_r7_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> in_valid);
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rd |=> $stable(cnt) && $stable(state));
    a_r5_frame_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FRAME_HEAD) |-> cnt == '0);
    a_r4_no_cmd_header: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HEAD_TAIL) |-> !cmd_wr);
endmodule

// File: rtl/tx_pkt_demux.sv
module tx_pkt_demux
    import tx_demux_pkg::*;
#(
    parameter int PKT_WORDS = 256,
    parameter int CNT_W     = 8,
    localparam int CW = $clog2(PKT_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_rd,
    input  logic              cmd_full,
    output logic              cmd_wr,
    output logic [DATA_W-1:0] cmd_data,
    input  logic [1:0]        ch_full,
    output logic [1:0]        ch_wr,
    output logic [DATA_W-1:0] ch_data,
    output logic [CNT_W-1:0]  bad_len_cnt
);
    dest_t         hdr_dest;
    logic [CW-1:0] hdr_pl;
    logic          hdr_bad, bump;

    txd_hdr_decode #(.PKT_WORDS(PKT_WORDS)) u_dec (
        .word(in_data), .dest(hdr_dest), .pl_words(hdr_pl), .too_long(hdr_bad)
    );

    txd_route_fsm #(.PKT_WORDS(PKT_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hdr_dest(hdr_dest), .hdr_pl(hdr_pl), .hdr_bad(hdr_bad),
        .cmd_full(cmd_full), .ch_full(ch_full),
        .in_rd(in_rd), .cmd_wr(cmd_wr), .ch_wr(ch_wr), .bump(bump)
    );

    txd_err_count #(.CNT_W(CNT_W)) u_err (
        .clk(clk), .rst_n(rst_n), .bump(bump), .count(bad_len_cnt)
    );

    assign cmd_data = in_data;
    assign ch_data  = in_data;
endmodule

// File: tb/tb_tx_pkt_demux.sv
module tb_tx_pkt_demux;
    localparam int PKT = 256;
    localparam int NV  = 10;
    // [31:27] chan [26:25] flags [24:16] bytes [15] stall [14] gap
    // [13:12] expected dest (0 none,1 ch0,2 ch1,3 cmd) [11:3] payload words [2] clamped
    localparam logic [31:0] VEC [NV] = '{
        {5'd0,  2'd0, 9'd20,  1'b0, 1'b0, 2'd1, 9'd10,  1'b0, 2'b0},
        {5'd1,  2'd2, 9'd7,   1'b0, 1'b0, 2'd2, 9'd4,   1'b0, 2'b0},
        {5'd31, 2'd1, 9'd12,  1'b0, 1'b0, 2'd3, 9'd6,   1'b0, 2'b0},
        {5'd0,  2'd3, 9'd0,   1'b0, 1'b0, 2'd1, 9'd0,   1'b0, 2'b0},
        {5'd1,  2'd0, 9'd504, 1'b1, 1'b0, 2'd2, 9'd252, 1'b0, 2'b0},
        {5'd5,  2'd0, 9'd30,  1'b1, 1'b0, 2'd0, 9'd15,  1'b0, 2'b0},
        {5'd31, 2'd0, 9'd100, 1'b1, 1'b1, 2'd3, 9'd50,  1'b0, 2'b0},
        {5'd0,  2'd0, 9'd510, 1'b0, 1'b0, 2'd1, 9'd252, 1'b1, 2'b0},
        {5'd1,  2'd1, 9'd33,  1'b0, 1'b1, 2'd2, 9'd17,  1'b0, 2'b0},
        {5'd31, 2'd2, 9'd511, 1'b1, 1'b0, 2'd3, 9'd252, 1'b1, 2'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_rd, cmd_full, cmd_wr;
    logic [15:0] in_data, cmd_data, ch_data;
    logic [1:0]  ch_full, ch_wr;
    logic [7:0]  bad_len_cnt;

    always #5 clk = ~clk;

    tx_pkt_demux dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_rd(in_rd),
        .cmd_full(cmd_full), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .ch_full(ch_full), .ch_wr(ch_wr), .ch_data(ch_data), .bad_len_cnt(bad_len_cnt)
    );

    int checks = 0, errors = 0;
    int n_cmd, n_c0, n_c1, viol;
    logic [15:0] cap_cmd [512];
    logic [15:0] cap_c0  [512];
    logic [15:0] cap_c1  [512];

    function automatic logic [15:0] word_of(int p, int k, logic [31:0] v);
        if (k == 0) return {v[31:27], v[26:25], v[24:16]};
        if (k == 1) return 16'hA5A5 ^ 16'(p);
        if (k == 2) return 16'(p * 16 + 3);
        if (k == 3) return 16'h7000 | 16'(p);
        return 16'((p << 10) ^ k ^ 16'h0150);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(int p, logic [31:0] v);
        int idx = 0, cyc = 0;
        n_cmd = 0; n_c0 = 0; n_c1 = 0; viol = 0;
        while (idx < PKT && cyc < 5000) begin
            @(negedge clk);
            in_valid = !(v[14] && cyc % 5 == 4);
            in_data  = word_of(p, idx, v);
            cmd_full = v[15] && cyc % 3 != 2;
            ch_full  = {2{v[15] && cyc % 3 != 2}};
            #1;
            if ($countones({cmd_wr, ch_wr}) > 1) viol++;
            if ((cmd_wr || ch_wr != 2'b00) && !in_rd) viol++;
            if (in_rd && !in_valid) viol++;
            if (cmd_wr) begin
                if (cmd_data != in_data || cmd_full) viol++;
                cap_cmd[n_cmd] = cmd_data; n_cmd++;
            end
            if (ch_wr[0]) begin
                if (ch_data != in_data || ch_full[0]) viol++;
                cap_c0[n_c0] = ch_data; n_c0++;
            end
            if (ch_wr[1]) begin
                if (ch_data != in_data || ch_full[1]) viol++;
                cap_c1[n_c1] = ch_data; n_c1++;
            end
            if (in_rd) idx++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; cmd_full = 1'b0; ch_full = 2'b00;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int exp_bad = 0;
        in_valid = 1'b0; in_data = '0; cmd_full = 1'b0; ch_full = 2'b00;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(bad_len_cnt == 0, "R1 count after reset", bad_len_cnt, 0);
        chk(!in_rd && !cmd_wr && ch_wr == 2'b00, "R1 idle outputs", {in_rd, cmd_wr, ch_wr}, 0);

        // R7: channel-0 header held back while its FIFO is full
        begin
            int pops = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                in_valid = 1'b1; in_data = {5'd0, 2'd0, 9'd8}; ch_full = 2'b01; #1;
                if (in_rd || ch_wr != 2'b00) pops++;
            end
            chk(pops == 0, "R7 stall on full channel", pops, 0);
        end
        // R7: command header drains while the command FIFO is full (no edge taken)
        @(negedge clk);
        in_valid = 1'b1; in_data = {5'd31, 2'd0, 9'd8}; ch_full = 2'b00; cmd_full = 1'b1; #1;
        chk(in_rd && !cmd_wr, "R7 command header not blocked", in_rd, 1);
        in_data = {5'd9, 2'd0, 9'd8}; ch_full = 2'b11; #1;
        chk(in_rd && !cmd_wr && ch_wr == 2'b00, "R6 unknown channel not blocked", in_rd, 1);
        in_valid = 1'b0; cmd_full = 1'b0; ch_full = 2'b00;

        for (int p = 0; p < NV; p++) begin
            logic [31:0] v = VEC[p];
            int d = int'(v[13:12]);
            int pw = int'(v[11:3]);
            int mism = 0;
            int exp_c0 = (d == 1) ? pw + 4 : 0;
            int exp_c1 = (d == 2) ? pw + 4 : 0;
            int exp_cm = (d == 3) ? pw : 0;
            send(p, v);
            chk(viol == 0, "R9 write framing", viol, 0);
            chk(n_c0 == exp_c0, "R3 R5 channel 0 word count", n_c0, exp_c0);
            chk(n_c1 == exp_c1, "R3 R5 channel 1 word count", n_c1, exp_c1);
            chk(n_cmd == exp_cm, "R4 R6 command word count", n_cmd, exp_cm);
            for (int j = 0; j < n_c0 && j < exp_c0; j++)
                if (cap_c0[j] != word_of(p, j, v)) mism++;
            for (int j = 0; j < n_c1 && j < exp_c1; j++)
                if (cap_c1[j] != word_of(p, j, v)) mism++;
            for (int j = 0; j < n_cmd && j < exp_cm; j++)
                if (cap_cmd[j] != word_of(p, j + 4, v)) mism++;
            chk(mism == 0, "R2 R3 R4 R10 routed contents", mism, 0);
            if (v[2]) exp_bad++;
            chk(int'(bad_len_cnt) == exp_bad, "R8 clamp count", bad_len_cnt, exp_bad);
        end

        @(negedge clk); #1;
        chk(!cmd_wr && ch_wr == 2'b00 && !in_rd, "R1 quiet after packets", {cmd_wr, ch_wr}, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule